// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

A single-channel engine that moves a block of words between one peripheral and system memory without the processor touching each word. Software loads four settings through a small write port: a transfer direction, a device address, a starting memory address and a word count. A start command then hands the job to the controller. For every word, it waits until the peripheral says it is ready. It then requests the system bus and, once the bus is granted, uses exactly one bus cycle to move the word. After that cycle it gives the bus back.

The peripheral is wired straight to the controller. Each word therefore crosses the system bus only once, between the controller and memory. The processor never switches context for a word; it only loses the single cycle it would have spent on the bus. When the last word has moved, the controller raises an interrupt. The interrupt stays up until software clears it.

Top module: `steal_dma`

## Requirements
- R1: After synchronous reset, `busy`, `irq`, `bus_req`, `mem_en`, `mem_we`, `dev_rd` and `dev_wr` are all low.
- R2: A configuration write selects its target with `cfg_sel`:
  - 0 is the command word. Bit 0 sets the direction: 0 moves device to memory, 1 moves memory to device. Bit 1 starts a transfer. Bit 2 clears the interrupt.
  - 1 is the device address. Its low `DVW` bits are held and shown on `dev_addr` from the next cycle on.
  - 2 is the starting memory address.
  - 3 is the word count.
- R3: A start command given while idle with a non-zero count raises `busy` in the next cycle.
- R4: While busy, `bus_req` rises only in the cycle after `dev_rdy` was sampled high. Once raised, it stays high until the transfer cycle.
- R5: The transfer cycle (`mem_en` high) comes in the cycle after `bus_gnt` is sampled high with `bus_req` high. It lasts exactly one cycle, and `bus_req` is low in the cycle that follows it.
- R6: For device-to-memory transfers, the transfer cycle drives `mem_we` high, places `dev_rdata` on `mem_wdata`, and pulses `dev_rd`.
- R7: For memory-to-device transfers, the transfer cycle keeps `mem_we` low, places `mem_rdata` on `dev_wdata`, and pulses `dev_wr`.
- R8: Successive transfer cycles present consecutive memory addresses, starting from the programmed address and wrapping modulo 2^AW. The memory pointer keeps its final value after a block, so a later start without a new address continues from there.
- R9: After the transfer cycle of the last word, `busy` is low and `irq` is high in the next cycle.
- R10: A start command with a count of zero raises `irq` in the next cycle. No bus request and no transfer cycle occur, and `busy` stays low.
- R11: `irq` stays high until an idle command write with bit 2 set. It is low in the cycle after that write.
- R12: Every configuration write made while `busy` is high is ignored, including start and clear commands. The device address, memory pointer, count and direction keep the values of the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | AW | Configuration write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Block-complete interrupt |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_en | output | 1 | Memory access in this cycle (transfer cycle) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |
| dev_addr | output | DVW | Selected device address |
| dev_rdy | input | 1 | Peripheral ready for one word |
| dev_rdata | input | DW | Word offered by the peripheral |
| dev_rd | output | 1 | Peripheral word consumed |
| dev_wdata | output | DW | Word delivered to the peripheral |
| dev_wr | output | 1 | Peripheral word delivered |

## Verification
Every result is due one rising edge after its cause, and the bench samples each one at the falling edge that follows that edge:
- `busy` follows the start write.
- `bus_req` follows the sampled `dev_rdy`.
- The transfer cycle follows the sampled grant.
- `irq` with `busy` low follows the final transfer cycle, or the start write when the count is zero.
- `irq` falls after the clear write.

Directed passes hold ready and grant low for several cycles to show that no output moves early. They then release them one at a time. Random passes mix direction, address, count, ready and grant, and compare every address and data word the monitor records against values the bench predicts on its own.

// File: rtl/csdma_pkg.sv
package csdma_pkg;

    // Configuration targets selected by cfg_sel
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DEV  = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_CNT  = 2'd3
    } cfg_sel_e;

    // Bit positions inside the command word
    localparam int CMD_DIR_BIT = 0;
    localparam int CMD_GO_BIT  = 1;
    localparam int CMD_CLR_BIT = 2;
    localparam int CMD_W       = 3;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } xfer_dir_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_REQ,
        ST_XFER
    } seq_state_e;

    typedef struct packed {
        logic      clr;
        logic      go;
        xfer_dir_e dir;
    } cmd_word_t;

    function automatic cmd_word_t decode_cmd(input logic [CMD_W-1:0] bits);
        cmd_word_t c;
        c.clr = bits[CMD_CLR_BIT];
        c.go  = bits[CMD_GO_BIT];
        c.dir = xfer_dir_e'(bits[CMD_DIR_BIT]);
        return c;
    endfunction

endpackage

// File: rtl/csd_regs.sv
module csd_regs
    import csdma_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int DVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  cfg_sel_e        sel,
    input  logic [AW-1:0]   wdata,
    input  xfer_dir_e       dir_in,
    input  logic            step,
    output xfer_dir_e       dir,
    output logic [DVW-1:0]  dev_addr,
    output logic [AW-1:0]   mem_ptr,
    output logic [CW-1:0]   count,
    output logic            cnt_zero,
    output logic            cnt_one
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [AW-1:0] PTR_ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir      <= DIR_DEV2MEM;
            dev_addr <= '0;
            mem_ptr  <= '0;
            count    <= '0;
        end else if (step) begin
            mem_ptr <= mem_ptr + PTR_ONE;
            count   <= count - CNT_ONE;
        end else if (wr_en) begin
            unique case (sel)
                SEL_CTRL: dir      <= dir_in;
                SEL_DEV:  dev_addr <= wdata[DVW-1:0];
                SEL_ADDR: mem_ptr  <= wdata;
                SEL_CNT:  count    <= wdata[CW-1:0];
                default:  ;
            endcase
        end
    end

    assign cnt_zero = (count == '0);
    assign cnt_one  = (count == CNT_ONE);

endmodule

// File: rtl/csd_seq.sv
module csd_seq
    import csdma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic clr,
    input  logic cnt_zero,
    input  logic cnt_one,
    input  logic dev_rdy,
    input  logic bus_gnt,
    output logic busy,
    output logic bus_req,
    output logic xfer,
    output logic irq
);

    seq_state_e state, state_nx;
    logic       done_now;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go && !cnt_zero) state_nx = ST_ARMED;
            ST_ARMED: if (dev_rdy)         state_nx = ST_REQ;
            ST_REQ:   if (bus_gnt)         state_nx = ST_XFER;
            ST_XFER:  state_nx = cnt_one ? ST_IDLE : ST_ARMED;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Completion: last word moved, or an empty block was started
    assign done_now = ((state == ST_XFER) && cnt_one) ||
                      ((state == ST_IDLE) && go && cnt_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            irq   <= 1'b0;
        end else begin
            state <= state_nx;
            if (done_now)  irq <= 1'b1;
            else if (clr)  irq <= 1'b0;
        end
    end

    assign busy    = (state != ST_IDLE);
    assign bus_req = (state == ST_REQ) || (state == ST_XFER);
    assign xfer    = (state == ST_XFER);

endmodule

// File: rtl/csd_path.sv
module csd_path
    import csdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          xfer,
    input  xfer_dir_e     dir,
    input  logic [AW-1:0] mem_ptr,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] dev_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          dev_rd,
    output logic          dev_wr,
    output logic [DW-1:0] dev_wdata
);

    logic to_mem;
    logic to_dev;

    assign to_mem = xfer && (dir == DIR_DEV2MEM);
    assign to_dev = xfer && (dir == DIR_MEM2DEV);

    // Bus lines stay at zero outside the stolen cycle
    assign mem_en    = xfer;
    assign mem_addr  = xfer   ? mem_ptr   : '0;
    assign mem_we    = to_mem;
    assign mem_wdata = to_mem ? dev_rdata : '0;
    assign dev_rd    = to_mem;
    assign dev_wr    = to_dev;
    assign dev_wdata = to_dev ? mem_rdata : '0;

endmodule

// File: rtl/steal_dma.sv
module steal_dma
    import csdma_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int DVW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    output logic           busy,
    output logic           irq,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DVW-1:0] dev_addr,
    input  logic           dev_rdy,
    input  logic [DW-1:0]  dev_rdata,
    output logic           dev_rd,
    output logic [DW-1:0]  dev_wdata,
    output logic           dev_wr
);

    cfg_sel_e      sel;
    cmd_word_t     cmd;
    logic          wr_ok;
    logic          cmd_hit;
    logic          go;
    logic          clr;
    logic          xfer;
    logic          cnt_zero;
    logic          cnt_one;
    xfer_dir_e     dir;
    logic [AW-1:0] mem_ptr;
    logic [CW-1:0] count;

    assign sel     = cfg_sel_e'(cfg_sel);
    assign cmd     = decode_cmd(cfg_wdata[CMD_W-1:0]);
    assign wr_ok   = cfg_we && !busy;
    assign cmd_hit = wr_ok && (sel == SEL_CTRL);
    assign go      = cmd_hit && cmd.go;
    assign clr     = cmd_hit && cmd.clr;

    csd_regs #(.AW(AW), .CW(CW), .DVW(DVW)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ok),
        .sel      (sel),
        .wdata    (cfg_wdata),
        .dir_in   (cmd.dir),
        .step     (xfer),
        .dir      (dir),
        .dev_addr (dev_addr),
        .mem_ptr  (mem_ptr),
        .count    (count),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    csd_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .clr      (clr),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .dev_rdy  (dev_rdy),
        .bus_gnt  (bus_gnt),
        .busy     (busy),
        .bus_req  (bus_req),
        .xfer     (xfer),
        .irq      (irq)
    );

    csd_path #(.AW(AW), .DW(DW)) i_path (
        .xfer      (xfer),
        .dir       (dir),
        .mem_ptr   (mem_ptr),
        .mem_rdata (mem_rdata),
        .dev_rdata (dev_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .dev_rd    (dev_rd),
        .dev_wr    (dev_wr),
        .dev_wdata (dev_wdata)
    );

endmodule

// File: rtl/steal_dma_chk.sv
module steal_dma_chk #(
    parameter int AW  = 16,
    parameter int DVW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_we,
    input logic [1:0]     cfg_sel,
    input logic [AW-1:0]  cfg_wdata,
    input logic           busy,
    input logic           irq,
    input logic           bus_req,
    input logic           bus_gnt,
    input logic           mem_en,
    input logic           dev_rdy,
    input logic           dev_rd,
    input logic           dev_wr,
    input logic [DVW-1:0] dev_addr
);

    // R4
    req_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> ($past(dev_rdy) && $past(busy)));

    // R5
    xfer_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> ($past(bus_gnt) && $past(bus_req)));

    // R5
    single_steal_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> (!mem_en && !bus_req));

    // R6
    strobe_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_rd || dev_wr) |-> (mem_en && busy && bus_req));

    // R9
    done_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_req && !mem_en));

    // R11
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(irq) && !($past(cfg_we) && ($past(cfg_sel) == 2'd0) && $past(cfg_wdata[2])))
        |-> irq);

    // R12
    busy_locks_dev_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> $stable(dev_addr));

endmodule

bind steal_dma steal_dma_chk #(.AW(AW), .DVW(DVW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .irq       (irq),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_en    (mem_en),
    .dev_rdy   (dev_rdy),
    .dev_rd    (dev_rd),
    .dev_wr    (dev_wr),
    .dev_addr  (dev_addr)
);

// File: tb/test_steal_dma.sv
`timescale 1ns/1ps
module test_steal_dma;

    localparam int AW = 16, DW = 16, CW = 16, DVW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_sel = 2'd0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic           busy, irq, bus_req, mem_en, mem_we, dev_rd, dev_wr;
    logic           bus_gnt = 1'b0;
    logic           dev_rdy = 1'b0;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata, dev_rdata, dev_wdata;
    logic [DVW-1:0] dev_addr;

    steal_dma #(.AW(AW), .DW(DW), .CW(CW), .DVW(DVW)) i_steal_dma (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dev_addr(dev_addr), .dev_rdy(dev_rdy),
        .dev_rdata(dev_rdata), .dev_rd(dev_rd), .dev_wdata(dev_wdata), .dev_wr(dev_wr)
    );

    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [15:0] init_word(int i);
        logic [31:0] t = 32'(i) * 32'd40503 + 32'd17;
        return t[15:0];
    endfunction

    function automatic logic [15:0] src_word(int k);
        logic [31:0] t = 32'(k) * 32'h9E3779B1;
        return t[31:16] ^ 16'h5A5A;
    endfunction

    // Memory model: 256 words, same-cycle read
    logic [15:0] mem [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
        end else if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr[7:0]];

    // Peripheral model: endless source, 1024-word sink
    int rd_idx, wr_idx;
    logic [15:0] sink [1024];
    always @(posedge clk) begin
        if (rst) begin
            rd_idx <= 0;
            wr_idx <= 0;
        end else begin
            if (dev_rd) rd_idx <= rd_idx + 1;
            if (dev_wr) begin
                sink[wr_idx % 1024] <= dev_wdata;
                wr_idx <= wr_idx + 1;
            end
        end
    end
    assign dev_rdata = src_word(rd_idx);

    // Monitor of transfer-cycle addresses
    int nlog = 0;
    logic [15:0] log_a [1024];
    always @(negedge clk) begin
        if (!rst && mem_en) begin
            log_a[nlog % 1024] = mem_addr;
            nlog = nlog + 1;
        end
    end

    // Ready / grant drivers, just after the falling edge
    bit rdy_force = 1'b1, rdy_val = 1'b0;
    bit gnt_manual = 1'b1, gnt_val = 1'b0;
    always @(negedge clk) begin
        #1;
        dev_rdy = rdy_force ? rdy_val : (($urandom % 4) != 0);
        bus_gnt = gnt_manual ? gnt_val : (bus_req && (($urandom % 3) != 0));
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        for (int n = 0; n < 3000; n++) begin
            if (irq) break;
            @(negedge clk);
        end
        chk(req, 32'(irq), 32'd1);
    endtask

    // Program, start, finish and check a whole block
    task automatic do_block(input bit dir, input logic [7:0] dv, input bit set_addr,
                            input logic [15:0] addr, input int cnt);
        logic [15:0] exp_d [16];
        int base = nlog;
        int rb   = rd_idx;
        int wb   = wr_idx;
        for (int i = 0; i < cnt; i++) exp_d[i] = mem[8'(addr + 16'(i))];
        cfg_write(2'd1, {8'h00, dv});
        if (set_addr) cfg_write(2'd2, addr);
        cfg_write(2'd3, 16'(cnt));
        cfg_write(2'd0, {13'd0, 1'b0, 1'b1, dir});
        chk("R3 busy after start", 32'(busy), 32'd1);
        wait_irq("R9 irq at block end");
        chk("R9 busy low at end", 32'(busy), 32'd0);
        chk("R8 transfer cycle count", 32'(nlog - base), 32'(cnt));
        for (int i = 0; i < cnt; i++) begin
            chk("R8 sequential address", 32'(log_a[(base + i) % 1024]), 32'(16'(addr + 16'(i))));
            if (!dir) chk("R6 word in memory", 32'(mem[8'(addr + 16'(i))]), 32'(src_word(rb + i)));
            else      chk("R7 word at device", 32'(sink[(wb + i) % 1024]), 32'(exp_d[i]));
        end
        cfg_write(2'd0, 16'h0004);
        chk("R11 clear", 32'(irq), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int base;
        int rb;
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 mem_en/we", 32'({mem_en, mem_we}), 0);
        chk("R1 dev strobes", 32'({dev_rd, dev_wr}), 0);

        // R2 device address truncated to DVW bits
        cfg_write(2'd1, 16'h015A);
        chk("R2 dev_addr", 32'(dev_addr), 32'h5A);

        // Directed timing, device to memory, one word
        cfg_write(2'd2, 16'h0040);
        cfg_write(2'd3, 16'd1);
        rb = rd_idx;
        cfg_write(2'd0, 16'h0002);
        chk("R3 busy", 32'(busy), 1);
        chk("R4 no req yet", 32'(bus_req), 0);
        repeat (3) @(negedge clk);
        chk("R4 no req without ready", 32'(bus_req), 0);
        rdy_val = 1'b1;
        @(negedge clk);
        chk("R4 req after ready", 32'(bus_req), 1);
        rdy_val = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 req held", 32'(bus_req), 1);
        chk("R5 no xfer without grant", 32'(mem_en), 0);
        gnt_val = 1'b1;
        @(negedge clk);
        chk("R5 xfer after grant", 32'(mem_en), 1);
        chk("R6 mem_we", 32'(mem_we), 1);
        chk("R6 dev_rd", 32'(dev_rd), 1);
        chk("R6 data path", 32'(mem_wdata), 32'(src_word(rb)));
        chk("R8 first address", 32'(mem_addr), 32'h40);
        gnt_val = 1'b0;
        @(negedge clk);
        chk("R5 one cycle", 32'(mem_en), 0);
        chk("R5 req dropped", 32'(bus_req), 0);
        chk("R9 busy low", 32'(busy), 0);
        chk("R9 irq high", 32'(irq), 1);
        chk("R6 memory written", 32'(mem[8'h40]), 32'(src_word(rb)));
        repeat (4) @(negedge clk);
        chk("R11 irq holds", 32'(irq), 1);
        cfg_write(2'd0, 16'h0004);
        chk("R11 irq cleared", 32'(irq), 0);

        // Directed memory to device, one word
        rdy_val = 1'b1; gnt_val = 1'b1;
        cfg_write(2'd2, 16'h0041);
        cfg_write(2'd3, 16'd1);
        v = mem[8'h41];
        cfg_write(2'd0, 16'h0003);
        for (int n = 0; n < 20 && !mem_en; n++) @(negedge clk);
        chk("R7 mem_we low", 32'(mem_we), 0);
        chk("R7 dev_wr", 32'(dev_wr), 1);
        chk("R7 dev_wdata", 32'(dev_wdata), 32'(v));
        wait_irq("R9 irq");
        cfg_write(2'd0, 16'h0004);

        // R10 zero count
        cfg_write(2'd3, 16'd0);
        base = nlog;
        cfg_write(2'd0, 16'h0002);
        chk("R10 irq at once", 32'(irq), 1);
        chk("R10 not busy", 32'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R10 no request", 32'(bus_req), 0);
        chk("R10 no transfer", 32'(nlog - base), 0);
        cfg_write(2'd0, 16'h0004);

        // R12 writes while busy are ignored
        rdy_val = 1'b0;
        cfg_write(2'd1, 16'h0033);
        cfg_write(2'd2, 16'h0100);
        cfg_write(2'd3, 16'd3);
        rb = rd_idx;
        cfg_write(2'd0, 16'h0002);
        cfg_write(2'd1, 16'h0077);
        cfg_write(2'd3, 16'd9);
        cfg_write(2'd2, 16'h0999);
        cfg_write(2'd0, 16'h0007);
        chk("R12 dev_addr kept", 32'(dev_addr), 32'h33);
        chk("R12 still busy", 32'(busy), 1);
        base = nlog;
        rdy_val = 1'b1;
        wait_irq("R12 block ends");
        chk("R12 count kept", 32'(nlog - base), 3);
        for (int i = 0; i < 3; i++) begin
            chk("R12 address kept", 32'(log_a[(base + i) % 1024]), 32'(16'h0100 + 16'(i)));
            chk("R12 direction kept", 32'(mem[8'(i)]), 32'(src_word(rb + i)));
        end
        cfg_write(2'd0, 16'h0004);
        base = nlog;
        cfg_write(2'd0, 16'h0002);
        chk("R12 count register empty", 32'(irq), 1);
        chk("R12 no extra words", 32'(nlog - base), 0);
        cfg_write(2'd0, 16'h0004);

        // R8 pointer continues, then wraps
        do_block(1'b0, 8'h12, 1'b0, 16'h0103, 2);
        do_block(1'b1, 8'h13, 1'b1, 16'hFFFE, 4);

        // Random blocks
        rdy_force = 1'b0; gnt_manual = 1'b0;
        for (int t = 0; t < 24; t++) begin
            do_block(1'($urandom % 2), 8'($urandom), 1'b1, 16'($urandom),
                     1 + int'($urandom % 12));
        end

        summary();
        $finish;
    end

endmodule